// File: doc/BRIEF.md
# Per-Destination Layer Spreading Poller

This block sits in a source edge node in front of K parallel layer queues, where each layer is one wavelength of the outgoing multiplex. Every packet offered at its input carries a destination index. The block keeps one round-robin pointer per destination. It offers the packet to exactly one layer queue: the first live layer at or after that destination's pointer. The packet leaves tagged with its destination and layer.

Because each destination walks its own deterministic sequence of layers, a receiver that knows the failed-layer mask can replay the same order to put the flow back together. A failed-layer mask removes dead layers from every sequence at once. The path through the block is purely combinational. The only state is the pointer table, and a pointer moves only when the selected layer queue accepts the packet.

Top module: `layer_spread_poller`

## Requirements
- R1: After reset every destination pointer is layer 0, so with no layer failed the first accepted packet for any destination is offered to layer 0; while reset is active and in_valid is low, out_valid is all zeros.
- R2: With no layer failed, successive accepted packets for one destination go to layers 0, 1, ..., K-1 and then wrap to 0.
- R3: The pointer of each destination changes only when a packet for that destination is accepted; packets for other destinations leave it untouched.
- R4: The offered layer is the first layer, scanning upward from the destination's pointer with wraparound, whose fail_mask bit is 0; a layer whose fail_mask bit is 1 never has its out_valid bit set.
- R5: On an accepted packet the destination's pointer becomes the first live layer after the chosen one (with wraparound, using the mask of that cycle), or the chosen layer itself if it is the only live one.
- R6: When every fail_mask bit is 1, in_ready is 0 and out_valid is all zeros, and no pointer moves.
- R7: When the chosen layer's out_ready is 0, in_ready is 0, the pointer does not move and the same layer keeps being offered; the packet is never redirected to another layer.
- R8: out_valid is one-hot at bit out_layer when in_valid is 1 and some layer is live, and out_data and out_dest equal in_data and in_dest in the same cycle; in_ready equals out_ready of the chosen layer.
- R9: A change of fail_mask between packets affects only the next assignment: the stored pointer is kept, and the next packet goes to the first live layer at or after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Packet offered at the input |
| in_ready | output | 1 | Packet accepted this cycle when in_valid is also high |
| in_dest | input | $clog2(N_DEST) | Destination index of the offered packet |
| in_data | input | DATA_W | Packet payload word |
| fail_mask | input | K_LAYERS | Bit k set marks layer k as failed |
| out_valid | output | K_LAYERS | One-hot offer to the selected layer queue |
| out_ready | input | K_LAYERS | Per-layer queue ready |
| out_data | output | DATA_W | Payload towards the layer queues |
| out_dest | output | $clog2(N_DEST) | Destination tag |
| out_layer | output | $clog2(K_LAYERS) | Layer tag, the index of the offered layer |

## Verification
Every output is combinational from the inputs and the stored pointer, so the layer choice, handshake and tags are due in the cycle the stimulus is applied. The bench drives on the falling edge and samples one nanosecond later, well before the next rising edge. A pointer update appears in the layer offered for that destination's next packet, one rising edge after the accepting cycle. The bench's reference model advances its own pointer table only after a cycle it predicted as accepted, and compares the next offer against that table.

// File: rtl/lsp_pkg.sv
`timescale 1ns/1ps
package lsp_pkg;

    // Upper bound on layers supported by the scan helpers.
    localparam int unsigned MAX_LAYERS = 64;

    // Increment a layer index modulo lim.
    function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned lim);
        return (v + 1 >= lim) ? 0 : v + 1;
    endfunction

endpackage

// File: rtl/lsp_layer_pick.sv
`timescale 1ns/1ps
module lsp_layer_pick #(
    parameter int unsigned K_LAYERS = 4,
    parameter int unsigned LW       = 2
) (
    input  logic [LW-1:0]       start_i,
    input  logic [K_LAYERS-1:0] alive_i,
    output logic [LW-1:0]       pick_o,
    output logic                found_o
);
    import lsp_pkg::*;

    int unsigned scan_idx;

    // First live layer at or after start_i, wrapping at K_LAYERS.
    always_comb begin
        found_o  = 1'b0;
        pick_o   = start_i;
        scan_idx = int'(start_i);
        for (int off = 0; off < int'(K_LAYERS); off++) begin
            if (!found_o && alive_i[scan_idx]) begin
                found_o = 1'b1;
                pick_o  = LW'(scan_idx);
            end
            scan_idx = wrap_inc(scan_idx, K_LAYERS);
        end
    end

endmodule

// File: rtl/lsp_ptr_table.sv
`timescale 1ns/1ps
module lsp_ptr_table #(
    parameter int unsigned N_DEST = 8,
    parameter int unsigned DW     = 3,
    parameter int unsigned LW     = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] rd_dest_i,
    output logic [LW-1:0] rd_ptr_o,
    input  logic          wr_en_i,
    input  logic [DW-1:0] wr_dest_i,
    input  logic [LW-1:0] wr_ptr_i
);

    typedef struct packed {
        logic [N_DEST-1:0][LW-1:0] ptr;
    } tbl_state_t;

    tbl_state_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en_i) begin
            tbl_d.ptr[wr_dest_i] = wr_ptr_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign rd_ptr_o = tbl_q.ptr[rd_dest_i];

    // R3 / R7: pointers hold unless a packet is accepted.
    assert_hold_without_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(tbl_q.ptr));

    // R5: the accepting destination's pointer takes the computed successor.
    assert_ptr_written_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> tbl_q.ptr[$past(wr_dest_i)] == $past(wr_ptr_i));

endmodule

// File: rtl/layer_spread_poller.sv
`timescale 1ns/1ps
module layer_spread_poller #(
    parameter int unsigned N_DEST   = 8,
    parameter int unsigned K_LAYERS = 4,
    parameter int unsigned DATA_W   = 32,
    localparam int unsigned DW      = (N_DEST > 1) ? $clog2(N_DEST) : 1,
    localparam int unsigned LW      = (K_LAYERS > 1) ? $clog2(K_LAYERS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [DW-1:0]       in_dest,
    input  logic [DATA_W-1:0]   in_data,
    input  logic [K_LAYERS-1:0] fail_mask,
    output logic [K_LAYERS-1:0] out_valid,
    input  logic [K_LAYERS-1:0] out_ready,
    output logic [DATA_W-1:0]   out_data,
    output logic [DW-1:0]       out_dest,
    output logic [LW-1:0]       out_layer
);
    import lsp_pkg::*;

    logic [K_LAYERS-1:0] alive;
    logic [LW-1:0]       cur_ptr;
    logic [LW-1:0]       chosen;
    logic                any_alive;
    logic [LW-1:0]       succ_start;
    logic [LW-1:0]       succ_ptr;
    logic                succ_found;
    logic                accept;

    assign alive = ~fail_mask;

    lsp_ptr_table #(
        .N_DEST (N_DEST),
        .DW     (DW),
        .LW     (LW)
    ) ptr_tbl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_dest_i (in_dest),
        .rd_ptr_o  (cur_ptr),
        .wr_en_i   (accept),
        .wr_dest_i (in_dest),
        .wr_ptr_i  (succ_ptr)
    );

    // Layer for this packet: first live layer at or after the pointer.
    lsp_layer_pick #(
        .K_LAYERS (K_LAYERS),
        .LW       (LW)
    ) pick_cur_i (
        .start_i (cur_ptr),
        .alive_i (alive),
        .pick_o  (chosen),
        .found_o (any_alive)
    );

    assign succ_start = LW'(wrap_inc(int'(chosen), K_LAYERS));

    // Pointer successor: first live layer after the chosen one.
    lsp_layer_pick #(
        .K_LAYERS (K_LAYERS),
        .LW       (LW)
    ) pick_nxt_i (
        .start_i (succ_start),
        .alive_i (alive),
        .pick_o  (succ_ptr),
        .found_o (succ_found)
    );

    assign in_ready = any_alive && out_ready[chosen];
    assign accept   = in_valid && in_ready;

    for (genvar k = 0; k < int'(K_LAYERS); k++) begin : g_offer
        assign out_valid[k] = in_valid && any_alive && (chosen == LW'(k));
    end

    assign out_data  = in_data;
    assign out_dest  = in_dest;
    assign out_layer = chosen;

    assert_onehot_offer_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_valid));

    assert_accept_has_taker_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> ((out_valid & out_ready) != '0));

    assert_skip_failed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid & fail_mask) == '0);

    assert_dead_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (&fail_mask) |-> (!in_ready && (out_valid == '0)));

    assert_succ_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
        any_alive |-> (succ_found && !fail_mask[succ_ptr]));

    assert_no_redirect_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid && !in_ready) && in_valid && $stable(in_dest) && $stable(fail_mask))
        |-> $stable(out_layer));

endmodule

// File: tb/layer_spread_poller_tb_top.sv
`timescale 1ns/1ps
module layer_spread_poller_tb_top;

    localparam int N  = 8;
    localparam int K  = 4;
    localparam int DWID = 32;
    localparam int DW = $clog2(N);
    localparam int LW = $clog2(K);

    logic            clk = 1'b0;
    logic            rst_n;
    logic            in_valid;
    logic            in_ready;
    logic [DW-1:0]   in_dest;
    logic [DWID-1:0] in_data;
    logic [K-1:0]    fail_mask;
    logic [K-1:0]    out_valid;
    logic [K-1:0]    out_ready;
    logic [DWID-1:0] out_data;
    logic [DW-1:0]   out_dest;
    logic [LW-1:0]   out_layer;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;
    int ref_ptr [N];

    always #5 clk = ~clk;

    layer_spread_poller #(
        .N_DEST   (N),
        .K_LAYERS (K),
        .DATA_W   (DWID)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_dest   (in_dest),
        .in_data   (in_data),
        .fail_mask (fail_mask),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_dest  (out_dest),
        .out_layer (out_layer)
    );

    // First live layer at or after start; -1 when all failed.
    function automatic int ref_pick(input int start, input logic [K-1:0] mask);
        for (int off = 0; off < K; off++) begin
            int idx = (start + off) % K;
            if (!mask[idx]) return idx;
        end
        return -1;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one cycle, compare against the model, then advance the model.
    task automatic step(input logic v, input int d, input logic [K-1:0] m,
                        input logic [K-1:0] r, input string tag, output int got);
        logic [DWID-1:0] dat;
        int              exp_l;
        logic            exp_rdy;
        logic [K-1:0]    exp_vld;
        @(negedge clk);
        dat       = $urandom;
        in_valid  = v;
        in_dest   = DW'(d);
        in_data   = dat;
        fail_mask = m;
        out_ready = r;
        #1;
        exp_l   = ref_pick(ref_ptr[d], m);
        exp_rdy = (exp_l >= 0) && r[exp_l];
        exp_vld = (v && exp_l >= 0) ? (K'(1) << exp_l) : '0;
        chk({tag, " in_ready"}, 64'(in_ready), 64'(exp_rdy));
        chk({tag, " out_valid"}, 64'(out_valid), 64'(exp_vld));
        if (v && exp_l >= 0) begin
            chk({tag, " out_layer"}, 64'(out_layer), 64'(exp_l));
            chk({tag, " out_data"}, 64'(out_data), 64'(dat));
            chk({tag, " out_dest"}, 64'(out_dest), 64'(d));
        end
        got = int'(out_layer);
        if (v && exp_rdy) ref_ptr[d] = ref_pick((exp_l + 1) % K, m);
    endtask

    initial begin
        int got;
        void'($urandom(32'h5eed_0042));
        rst_n = 1'b0; in_valid = 1'b0; in_dest = '0; in_data = '0;
        fail_mask = '0; out_ready = '1;
        for (int i = 0; i < N; i++) ref_ptr[i] = 0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset out_valid", 64'(out_valid), 64'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 and R3: first packet of each destination lands on layer 0.
        for (int d = 0; d < N; d++) begin
            step(1'b1, d, '0, '1, "R1", got);
            chk("R1 first layer", 64'(got), 64'h0);
        end
        // R2: destination 2 walks 1,2,3 then wraps to 0.
        for (int i = 1; i <= K; i++) begin
            step(1'b1, 2, '0, '1, "R2", got);
            chk("R2 rotation", 64'(got), 64'(i % K));
        end
        // R3: destination 3 unaffected by destination 2 traffic.
        step(1'b1, 3, '0, '1, "R3", got);
        chk("R3 independent pointer", 64'(got), 64'h1);

        // R7: destination 4 at layer 1, layer 1 not ready: stall, no redirect.
        for (int i = 0; i < 3; i++) begin
            step(1'b1, 4, '0, 4'b1101, "R7", got);
            chk("R7 no redirect", 64'(got), 64'h1);
            chk("R7 stalled", 64'(in_ready), 64'h0);
        end
        step(1'b1, 4, '0, '1, "R7", got);
        chk("R7 accepted after stall", 64'(got), 64'h1);

        // R6: all layers failed; nothing accepted, pointer kept.
        for (int i = 0; i < 2; i++) begin
            step(1'b1, 4, '1, '1, "R6", got);
            chk("R6 ready low", 64'(in_ready), 64'h0);
            chk("R6 no offer", 64'(out_valid), 64'h0);
        end
        step(1'b1, 4, '0, '1, "R6", got);
        chk("R6 pointer kept", 64'(got), 64'h2);

        // R4/R5/R9: pointer now 3; layer 3 fails -> layer 0, next pointer 1.
        step(1'b1, 4, 4'b1000, '1, "R9", got);
        chk("R9 skip failed", 64'(got), 64'h0);
        step(1'b1, 4, '0, '1, "R9", got);
        chk("R9 mask cleared", 64'(got), 64'h1);
        // pointer 2; layers 1,2 failed -> 3, successor wraps to 0.
        step(1'b1, 4, 4'b0110, '1, "R4", got);
        chk("R4 first live at or after", 64'(got), 64'h3);
        step(1'b1, 4, 4'b0110, '1, "R5", got);
        chk("R5 successor wraps", 64'(got), 64'h0);
        // only layer 2 live: chosen twice in a row.
        step(1'b1, 4, 4'b1011, '1, "R5", got);
        chk("R5 sole live layer", 64'(got), 64'h2);
        step(1'b1, 4, 4'b1011, '1, "R5", got);
        chk("R5 sole live layer again", 64'(got), 64'h2);

        // Random phase.
        for (int i = 0; i < 4000; i++) begin
            logic [K-1:0] m;
            logic [K-1:0] r;
            m = ($urandom % 6 == 0) ? K'($urandom) : '0;
            r = '0;
            for (int k = 0; k < K; k++) r[k] = ($urandom % 4) != 0;
            step(($urandom % 4) != 0, int'($urandom % N), m, r, "R8 random", got);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule